// File: doc/BRIEF.md
# Serial DAC Write Sequencer

This block sits on the host side of a three-wire serial digital-to-analog converter. The converter has four control lines: an active-low select, a serial clock, a serial data line, and an active-low load strobe. It also has a separate active-low clear line. A client hands the sequencer a 12-bit code over a valid/ready handshake. The sequencer then selects the converter and shifts the code out with the most significant bit first. It releases the select, pulses the load strobe so the new code moves into the converter's output register, and signals completion with a one-cycle done pulse.

Every minimum duration on the wire comes from a run-time cycle count on a configuration input. These durations are the clock high and low times, the data setup and hold around each rising clock edge, the select setup and hold, the load setup, the load pulse width, the load recovery time and the clear pulse width. The sequencer always holds each phase for one cycle more than the programmed count. A phase that must meet two or three minimums at once lasts for the largest of them plus one cycle. At a 100 MHz system clock, a count of ceil(ns / 10) meets the nanosecond figure.

A separate one-cycle clear request drives the clear line low. If the request arrives while a write is in flight, the sequencer holds it and performs it once that write has finished.

Top module: `dac_write_seq`

## Requirements
- R1: Each accepted write produces exactly 12 rising edges on `dac_sck` while `dac_sel_n` is low and `dac_ld_n` is high. The `dac_sdo` values present at those edges are `req_code[11]` down to `req_code[0]`, in that order.
- R2: Each `dac_sck` high phase lasts max(`t_sck_hi`,`t_dat_hd`)+1 cycles. Each low phase between two bits lasts max(`t_sck_lo`,`t_dat_su`)+1 cycles.
- R3: `dac_sdo` changes only on the cycle in which `dac_sck` falls or while `dac_sck` is low. It is never changed while the clock stays high.
- R4: `dac_sel_n` falls on the cycle after acceptance and stays low for max(`t_sel_su`,`t_dat_su`)+1 cycles before the first rising clock. After the last high phase it stays low, with the clock low, for max(`t_sel_hd`,`t_ld_su`,`t_sck_lo`)+1 cycles.
- R5: `dac_ld_n` stays high while bits are shifted. It falls on the same cycle that `dac_sel_n` rises, and stays low for `t_ld_pw`+1 cycles.
- R6: After `dac_ld_n` rises, `busy` stays high for `t_ld_hd`+1 cycles. `done` is then high for exactly one cycle, the first idle cycle.
- R7: `req_ready` is high exactly when the sequencer is idle and no clear is pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `busy` is high from the next cycle.
- R8: A `clr_req` sampled while idle makes a clear pending for one cycle. `dac_clr_n` is then low for `t_clr_pw`+1 cycles with `busy` high, while select and load stay high and the clock stays low.
- R9: A `clr_req` sampled during a write drives `dac_clr_n` low only after that write's done pulse. A pending clear is served before any new request.
- R10: During and right after reset, the outputs are: `dac_sel_n`=1, `dac_sck`=0, `dac_sdo`=0, `dac_ld_n`=1, `dac_clr_n`=1, `busy`=0, `done`=0, `req_ready`=1.
- R11: Counts of zero give phases of one cycle each, and the bit order and all orderings above still hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request valid |
| req_ready | output | 1 | Sequencer can take a write |
| req_code | input | CODE_W | Code to write |
| clr_req | input | 1 | One-cycle request for a clear pulse |
| busy | output | 1 | A write or clear is in progress |
| done | output | 1 | One-cycle pulse at the end of each write |
| t_sck_hi | input | CNT_W | Minimum clock high time, cycles |
| t_sck_lo | input | CNT_W | Minimum clock low time, cycles |
| t_dat_su | input | CNT_W | Data setup before rising clock, cycles |
| t_dat_hd | input | CNT_W | Data hold after rising clock, cycles |
| t_sel_su | input | CNT_W | Select setup before first clock, cycles |
| t_sel_hd | input | CNT_W | Select hold after last clock, cycles |
| t_ld_su | input | CNT_W | Load setup after last clock, cycles |
| t_ld_pw | input | CNT_W | Load pulse width, cycles |
| t_ld_hd | input | CNT_W | Recovery after load before next write, cycles |
| t_clr_pw | input | CNT_W | Clear pulse width, cycles |
| dac_sel_n | output | 1 | Converter select, active low |
| dac_sck | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data to converter |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
Some orderings on the wire are checked by the assertions on every cycle. Data is held while the clock is high. Every rising clock edge falls inside a selected, unloaded window. The load strobe falls together with the select release. A clear never overlaps select, load or clock. Done never lasts two cycles. Phase lengths, the bit order of each code and the deferral of a clear behind a running write are shown only by the bench's scenarios, where a behavioural model predicts every output on every cycle. Those scenarios cover default, asymmetric and all-zero timing, requests held valid back to back, and a clear that collides with a write.

// File: rtl/dac_write_seq.sv
module dac_write_seq #(
  parameter int CODE_W = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic              clr_req,
  output logic              busy,
  output logic              done,
  input  logic [CNT_W-1:0]  t_sck_hi,
  input  logic [CNT_W-1:0]  t_sck_lo,
  input  logic [CNT_W-1:0]  t_dat_su,
  input  logic [CNT_W-1:0]  t_dat_hd,
  input  logic [CNT_W-1:0]  t_sel_su,
  input  logic [CNT_W-1:0]  t_sel_hd,
  input  logic [CNT_W-1:0]  t_ld_su,
  input  logic [CNT_W-1:0]  t_ld_pw,
  input  logic [CNT_W-1:0]  t_ld_hd,
  input  logic [CNT_W-1:0]  t_clr_pw,
  output logic              dac_sel_n,
  output logic              dac_sck,
  output logic              dac_sdo,
  output logic              dac_ld_n,
  output logic              dac_clr_n
);
  localparam int BW = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(CODE_W - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_HIGH, S_LOW, S_TAIL, S_LOAD, S_RECOV, S_CLEAR
  } state_t;

  state_t            st;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] shreg;
  logic [BW-1:0]     bitn;
  logic              clr_pend;
  logic              go_clr;

  function automatic logic [CNT_W-1:0] mx(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign go_clr    = (st == S_IDLE) && clr_pend;
  assign req_ready = (st == S_IDLE) && !clr_pend;
  assign busy      = (st != S_IDLE);
  assign dac_sck   = (st == S_HIGH);
  assign dac_sel_n = !((st == S_SETUP) || (st == S_HIGH) || (st == S_LOW) || (st == S_TAIL));
  assign dac_ld_n  = (st != S_LOAD);
  assign dac_clr_n = (st != S_CLEAR);
  assign dac_sdo   = shreg[CODE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      bitn     <= '0;
      clr_pend <= 1'b0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      clr_pend <= (clr_pend && !go_clr) || clr_req;
      if (st == S_IDLE) begin
        if (clr_pend) begin
          st  <= S_CLEAR;
          cnt <= t_clr_pw;
        end else if (req_valid) begin
          st    <= S_SETUP;
          cnt   <= mx(t_sel_su, t_dat_su);
          shreg <= req_code;
          bitn  <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          S_SETUP: begin
            st  <= S_HIGH;
            cnt <= mx(t_sck_hi, t_dat_hd);
          end
          S_HIGH: begin
            if (bitn == LAST_BIT) begin
              st  <= S_TAIL;
              cnt <= mx(mx(t_sel_hd, t_ld_su), t_sck_lo);
            end else begin
              st    <= S_LOW;
              cnt   <= mx(t_sck_lo, t_dat_su);
              bitn  <= bitn + 1'b1;
              shreg <= {shreg[CODE_W-2:0], 1'b0};
            end
          end
          S_LOW: begin
            st  <= S_HIGH;
            cnt <= mx(t_sck_hi, t_dat_hd);
          end
          S_TAIL: begin
            st  <= S_LOAD;
            cnt <= t_ld_pw;
          end
          S_LOAD: begin
            st  <= S_RECOV;
            cnt <= t_ld_hd;
          end
          S_RECOV: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_sck && $past(dac_sck)) |-> $stable(dac_sdo));

  // R1
  sck_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_sck) |-> (!dac_sel_n && dac_ld_n && dac_clr_n));

  // R5
  load_after_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_ld_n) |-> ($rose(dac_sel_n) && !dac_sck));

  // R8
  clear_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_clr_n |-> (dac_sel_n && dac_ld_n && !dac_sck && busy));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && !req_ready));

  // R9
  clear_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_clr_n) |-> $past(!busy));
endmodule

// File: tb/dac_write_seq_tb.sv
module dac_write_seq_tb;
  localparam int CLK_NS = 10;
  localparam int CW = 12;
  localparam int NW = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, clr_req = 1'b0;
  logic [CW-1:0] req_code = '0;
  logic req_ready, busy, done;
  logic [NW-1:0] t_sck_hi, t_sck_lo, t_dat_su, t_dat_hd, t_sel_su, t_sel_hd;
  logic [NW-1:0] t_ld_su, t_ld_pw, t_ld_hd, t_clr_pw;
  logic dac_sel_n, dac_sck, dac_sdo, dac_ld_n, dac_clr_n;

  always #(CLK_NS/2) clk = ~clk;

  dac_write_seq #(.CODE_W(CW), .CNT_W(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_code(req_code), .clr_req(clr_req), .busy(busy), .done(done),
    .t_sck_hi(t_sck_hi), .t_sck_lo(t_sck_lo), .t_dat_su(t_dat_su), .t_dat_hd(t_dat_hd),
    .t_sel_su(t_sel_su), .t_sel_hd(t_sel_hd), .t_ld_su(t_ld_su), .t_ld_pw(t_ld_pw),
    .t_ld_hd(t_ld_hd), .t_clr_pw(t_clr_pw), .dac_sel_n(dac_sel_n), .dac_sck(dac_sck),
    .dac_sdo(dac_sdo), .dac_ld_n(dac_ld_n), .dac_clr_n(dac_clr_n));

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // vector: busy done sel_n sck sdo ld_n clr_n
  function automatic logic [6:0] mk(input logic b, input logic d, input logic s,
      input logic k, input logic o, input logic l, input logic c);
    return {b, d, s, k, o, l, c};
  endfunction

  logic [6:0] q[$];
  logic [6:0] cur;
  logic m_pend;
  logic s_valid, s_clr;
  logic [CW-1:0] s_code;
  logic prev_sck, prev_sdo;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    s_valid <= req_valid;
    s_clr <= clr_req;
    s_code <= req_code;
  end

  task automatic push_write(input logic [CW-1:0] c);
    for (int n = 0; n < mx(t_sel_su, t_dat_su) + 1; n++) q.push_back(mk(1,0,0,0,c[CW-1],1,1));
    for (int i = CW-1; i >= 0; i--) begin
      for (int n = 0; n < mx(t_sck_hi, t_dat_hd) + 1; n++) q.push_back(mk(1,0,0,1,c[i],1,1));
      if (i > 0)
        for (int n = 0; n < mx(t_sck_lo, t_dat_su) + 1; n++) q.push_back(mk(1,0,0,0,c[i-1],1,1));
    end
    for (int n = 0; n < mx(mx(t_sel_hd, t_ld_su), t_sck_lo) + 1; n++) q.push_back(mk(1,0,0,0,c[0],1,1));
    for (int n = 0; n < t_ld_pw + 1; n++) q.push_back(mk(1,0,1,0,c[0],0,1));
    for (int n = 0; n < t_ld_hd + 1; n++) q.push_back(mk(1,0,1,0,c[0],1,1));
    q.push_back(mk(0,1,1,0,c[0],1,1));
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = mk(0,0,1,0,0,1,1);
      m_pend = 1'b0;
    end else begin
      if (!cur[6]) begin
        if (m_pend) begin
          for (int n = 0; n < t_clr_pw + 1; n++) q.push_back(mk(1,0,1,0,cur[2],1,0));
          m_pend = 1'b0;
        end else if (s_valid) begin
          push_write(s_code);
        end
      end
      if (s_clr) m_pend = 1'b1;
      if (q.size() > 0) cur = q.pop_front();
      else cur = mk(0,0,1,0,cur[2],1,1);
      chk("R6 busy", busy, cur[6]);
      chk("R6 done", done, cur[5]);
      chk("R4 dac_sel_n", dac_sel_n, cur[4]);
      chk("R2 dac_sck", dac_sck, cur[3]);
      chk("R1 dac_sdo", dac_sdo, cur[2]);
      chk("R5 dac_ld_n", dac_ld_n, cur[1]);
      chk("R8 dac_clr_n", dac_clr_n, cur[0]);
      chk("R7 req_ready", req_ready, !cur[6] && !m_pend);
      if (prev_sck && dac_sck) chk("R3 sdo held while clock high", dac_sdo, prev_sdo);
    end
    prev_sck = dac_sck;
    prev_sdo = dac_sdo;
  end

  logic [CW-1:0] cap;
  int ncap;
  always @(posedge dac_sck) begin
    cap = {cap[CW-2:0], dac_sdo};
    ncap++;
  end

  task automatic set_cfg(input int hi, input int lo, input int su, input int hd, input int ss,
      input int sh, input int ls, input int lw, input int lh, input int cw);
    t_sck_hi = NW'(hi); t_sck_lo = NW'(lo); t_dat_su = NW'(su); t_dat_hd = NW'(hd);
    t_sel_su = NW'(ss); t_sel_hd = NW'(sh); t_ld_su = NW'(ls); t_ld_pw = NW'(lw);
    t_ld_hd = NW'(lh); t_clr_pw = NW'(cw);
  endtask

  task automatic start_write(input logic [CW-1:0] c);
    @(negedge clk); #1;
    req_valid = 1'b1;
    req_code = c;
    while (!req_ready) begin @(negedge clk); #1; end
    ncap = 0;
    cap = '0;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input logic [CW-1:0] c, input string tag);
    while (!done) @(negedge clk);
    chk({tag, " bit count"}, ncap, CW);
    chk({tag, " captured code"}, int'(cap), int'(c));
  endtask

  task automatic write_and_check(input logic [CW-1:0] c, input string tag);
    start_write(c);
    wait_done(c, tag);
  endtask

  task automatic pulse_clr();
    @(negedge clk); #1;
    clr_req = 1'b1;
    @(posedge clk); #1;
    clr_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy || !req_ready) @(negedge clk);
  endtask

  initial begin
    int done_cyc;
    int clr_cyc;
    int low_cnt;
    set_cfg(4, 4, 2, 2, 4, 4, 2, 5, 4, 4);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 sel_n", dac_sel_n, 1); chk("R10 sck", dac_sck, 0); chk("R10 sdo", dac_sdo, 0);
    chk("R10 ld_n", dac_ld_n, 1); chk("R10 clr_n", dac_clr_n, 1); chk("R10 busy", busy, 0);
    chk("R10 done", done, 0); chk("R10 ready", req_ready, 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", req_ready, 1);

    // R1 R2 R4 R5 R6 default timing
    write_and_check(12'hA5C, "R1 default");
    write_and_check(12'hFFF, "R1 all ones");
    write_and_check(12'h000, "R1 all zeros");
    // R7 back-to-back with request held valid
    start_write(12'h801);
    start_write(12'h7FE);
    wait_done(12'h7FE, "R7 back-to-back");

    // R8 clear while idle
    wait_idle();
    pulse_clr();
    low_cnt = 0;
    while (dac_clr_n) @(negedge clk);
    while (!dac_clr_n) begin low_cnt++; @(negedge clk); end
    chk("R8 clear width", low_cnt, 5);
    chk("R8 sdo kept after clear", dac_sdo, 0);

    // R9 clear during write is deferred
    wait_idle();
    start_write(12'h3A6);
    repeat (20) @(negedge clk);
    pulse_clr();
    chk("R9 clear line high during write", dac_clr_n, 1);
    while (!done) @(negedge clk);
    done_cyc = cyc;
    chk("R9 ready low while clear pending", req_ready, 0);
    while (dac_clr_n) @(negedge clk);
    clr_cyc = cyc;
    chk("R9 clear after done", int'(clr_cyc > done_cyc), 1);

    // R9 clear and request in the same idle cycle: write first, clear after
    wait_idle();
    @(negedge clk); #1;
    req_valid = 1'b1; req_code = 12'h5C3; clr_req = 1'b1;
    ncap = 0; cap = '0;
    @(posedge clk); #1;
    req_valid = 1'b0; clr_req = 1'b0;
    wait_done(12'h5C3, "R9 coincident");
    while (dac_clr_n) @(negedge clk);
    chk("R9 coincident clear follows", dac_clr_n, 0);

    // R11 all counts zero
    wait_idle();
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    write_and_check(12'h3C9, "R11 zero counts");
    pulse_clr();
    wait_idle();

    // R2 asymmetric timing
    set_cfg(1, 6, 7, 3, 2, 9, 5, 3, 6, 2);
    write_and_check(12'h555, "R2 asymmetric");
    write_and_check(12'hAAA, "R2 asymmetric");
    wait_idle();
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule